// File: doc/BRIEF.md
# Cache Page Flush and Invalidate Controller

This block is a maintenance engine for a small write-back, set-associative L1 data cache. Software writes a single control word. The word names a 4-KB linear page and a per-page action: either flush, where modified lines are written back and then dropped, or invalidate-only, where lines are dropped with no write-back. The controller sends the page number to a translation unit through a request/acknowledge port. If translation succeeds, it walks every line address of the returned physical frame. At each address it probes every way of the line-state array. Matching lines are written back through a write-back request/acknowledge port where required, then marked invalid.

A failed translation leaves the cache untouched. The failure is recorded only in a sticky status bit that software reads back. The block has no exception output of any kind. Two pulse inputs start whole-cache walks: one writes back every modified line and invalidates all lines, and the other invalidates all lines with no write-back. Every walk reports a busy flag. While that flag is high, all new requests are dropped.

Top module: `page_maint_ctrl`

## Requirements
- R1: A control write accepted while idle makes `busy` high from the next cycle. It also raises `xl_req` with `xl_vpn` equal to bits 31:12 of the written word.
- R2: A translation acknowledged with `xl_fault` set causes the following. The status fault bit (read bit 1) becomes 1, no line is written back or changed, and `busy` drops. This holds for both per-page actions.
- R3: The fault bit reads 0 from the cycle after an accepted control write. It stays 0 when the translation succeeds.
- R4: Flush mode (written bit 0 = 0) writes back each modified line (state 3) of the page whose tag matches. The write-back address is {frame, line index}. `wb_req` and `wb_addr` hold until `wb_ack`. The line is marked invalid only in the acknowledged cycle.
- R5: Invalidate-only mode (written bit 0 = 1) marks every valid matching line invalid and issues no write-back.
- R6: Line states are encoded as follows: 0 invalid, 1 shared, 2 exclusive clean, 3 modified. In both per-page modes, matching shared and clean lines are invalidated without a write-back. Invalid lines and lines with another tag are left unchanged and cause no traffic.
- R7: The walk visits line indices in ascending order, and all ways of one index in ascending way order. Write-backs therefore appear in that order.
- R8: A `cmd_wbinv_all` pulse while idle needs no translation. It writes back every modified line with address {stored tag, set} in walk order, and leaves every line invalid.
- R9: A `cmd_inv_all` pulse while idle leaves every line invalid and issues no write-back.
- R10: While `busy`, control writes and commands are ignored. When idle, a control write wins over a same-cycle command, and `cmd_wbinv_all` wins over `cmd_inv_all`.
- R11: `reg_rdata` returns the following fields. Bits 31:12 hold the last accepted page number, bit 2 is busy, bit 1 is fault, bit 0 is the last accepted action bit, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word: page number and action bit |
| reg_rdata | output | 32 | Status readback |
| cmd_wbinv_all | input | 1 | Start whole-cache write-back and invalidate |
| cmd_inv_all | input | 1 | Start whole-cache invalidate |
| busy | output | 1 | Walk in progress |
| xl_req | output | 1 | Translation request, held until acknowledged |
| xl_vpn | output | 20 | Linear page number to translate |
| xl_ack | input | 1 | Translation done |
| xl_fault | input | 1 | Translation fault, valid with xl_ack |
| xl_pfn | input | 20 | Physical frame, valid with xl_ack |
| arr_set | output | 7 | Line-state array set index |
| arr_way | output | 1 | Line-state array way |
| arr_state | input | 2 | State of the addressed line (same-cycle read) |
| arr_tag | input | 20 | Tag of the addressed line (same-cycle read) |
| arr_wr | output | 1 | Mark the addressed line invalid at this edge |
| wb_req | output | 1 | Write-back request, held until acknowledged |
| wb_addr | output | 27 | Line address to write back |
| wb_ack | input | 1 | Write-back accepted |

## Verification
If the walker counter or the mode register is corrupted, the result is an out-of-order or missing write-back address. The scoreboard detects this at the first acknowledged write-back. If a line is dropped or wrongly kept, the line-state array differs from the model; this is seen when the walk ends, a few hundred cycles later. If the fault path is wrong, it shows up either as array writes during a faulting operation or as a wrong bit 1 in the readback. That readback is checked the cycle after the write and again once `busy` falls.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XL   = 2'd1,
    ST_SCAN = 2'd2,
    ST_WB   = 2'd3
  } pmc_st_e;

  typedef enum logic [1:0] {
    K_PG_FLUSH = 2'd0,
    K_PG_INV   = 2'd1,
    K_ALL_WB   = 2'd2,
    K_ALL_INV  = 2'd3
  } pmc_kind_e;

  function automatic logic kind_writes_back(input pmc_kind_e k);
    return (k == K_PG_FLUSH) || (k == K_ALL_WB);
  endfunction

  function automatic logic kind_whole(input pmc_kind_e k);
    return (k == K_ALL_WB) || (k == K_ALL_INV);
  endfunction
endpackage

// File: rtl/pmc_walk.sv
module pmc_walk #(
  parameter int IDX_W = 7,
  parameter int WAY_W = 1,
  parameter int WAYS  = 2,
  parameter int PGL_W = 7,
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             whole,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] way,
  output logic             last
);
  localparam logic [IDX_W-1:0] PG_TOP  = IDX_W'((1 << PGL_W) - 1);
  localparam logic [IDX_W-1:0] ALL_TOP = IDX_W'((1 << SET_W) - 1);
  localparam logic [WAY_W-1:0] WAY_TOP = WAY_W'(WAYS - 1);

  function automatic logic [IDX_W-1:0] idx_limit(input logic all_sets);
    return all_sets ? ALL_TOP : PG_TOP;
  endfunction

  logic way_wrap;
  assign way_wrap = (way == WAY_TOP);
  assign last     = way_wrap && (idx == idx_limit(whole));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      idx <= '0;
      way <= '0;
    end else if (step) begin
      if (way_wrap) begin
        way <= '0;
        idx <= idx + 1'b1;
      end else begin
        way <= way + 1'b1;
      end
    end
  end

  assert_walk_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !last && way_wrap) |=> (idx == $past(idx) + 1'b1) && (way == '0));
  assert_walk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(idx) && $stable(way));
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [ADDR_W-1:0]        wdata,
  input  logic                     fault_evt,
  input  logic                     busy,
  output logic [ADDR_W-PAGE_W-1:0] vpn,
  output logic                     inv_only,
  output logic                     fault,
  output logic [ADDR_W-1:0]        rdata
);
  localparam int VPN_W = ADDR_W - PAGE_W;

  logic unused_wbits;
  assign unused_wbits = ^wdata[PAGE_W-1:1];

  function automatic logic [ADDR_W-1:0] pack_status(
    input logic [VPN_W-1:0] p, input logic b, input logic f, input logic o);
    return {p, {(PAGE_W-3){1'b0}}, b, f, o};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn      <= '0;
      inv_only <= 1'b0;
      fault    <= 1'b0;
    end else if (accept) begin
      vpn      <= wdata[ADDR_W-1:PAGE_W];
      inv_only <= wdata[0];
      fault    <= 1'b0;
    end else if (fault_evt) begin
      fault    <= 1'b1;
    end
  end

  assign rdata = pack_status(vpn, busy, fault, inv_only);

  assert_fault_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rdata[1] && (rdata[ADDR_W-1:PAGE_W] == $past(wdata[ADDR_W-1:PAGE_W])));
  assert_fault_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !accept) |=> fault);
endmodule

// File: rtl/page_maint_ctrl.sv
module page_maint_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 5,
  parameter int SET_W  = 7,
  parameter int WAYS   = 2,
  localparam int VPN_W   = ADDR_W - PAGE_W,
  localparam int LADDR_W = ADDR_W - LINE_W,
  localparam int TAG_W   = LADDR_W - SET_W,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0]  reg_rdata,
  input  logic               cmd_wbinv_all,
  input  logic               cmd_inv_all,
  output logic               busy,
  output logic               xl_req,
  output logic [VPN_W-1:0]   xl_vpn,
  input  logic               xl_ack,
  input  logic               xl_fault,
  input  logic [VPN_W-1:0]   xl_pfn,
  output logic [SET_W-1:0]   arr_set,
  output logic [WAY_W-1:0]   arr_way,
  input  logic [1:0]         arr_state,
  input  logic [TAG_W-1:0]   arr_tag,
  output logic               arr_wr,
  output logic               wb_req,
  output logic [LADDR_W-1:0] wb_addr,
  input  logic               wb_ack
);
  localparam int PGL_W = PAGE_W - LINE_W;
  localparam int IDX_W = (PGL_W > SET_W) ? PGL_W : SET_W;

  function automatic logic [LADDR_W-1:0] page_line(
    input logic [VPN_W-1:0] frame, input logic [IDX_W-1:0] i);
    return {frame, i[PGL_W-1:0]};
  endfunction

  function automatic logic [SET_W-1:0] set_of(input logic [LADDR_W-1:0] l);
    return l[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LADDR_W-1:0] l);
    return l[LADDR_W-1:SET_W];
  endfunction

  pmc_st_e          st_q, st_d;
  pmc_kind_e        kind_q;
  logic [VPN_W-1:0] pfn_q;
  logic             start_pg, start_all, walk_start;
  logic             fault_evt, xl_ok_evt;
  logic             whole, wants_wb;
  logic [IDX_W-1:0] idx;
  logic             walk_last, step;
  logic [LADDR_W-1:0] line_cur;
  logic             tag_hit, line_live, hit, need_wb, wb_done;
  logic             st_inv_only, st_fault;

  assign start_pg   = reg_wr && (st_q == ST_IDLE);
  assign start_all  = !reg_wr && (cmd_wbinv_all || cmd_inv_all) && (st_q == ST_IDLE);
  assign walk_start = start_pg || start_all;
  assign fault_evt  = (st_q == ST_XL) && xl_ack && xl_fault;
  assign xl_ok_evt  = (st_q == ST_XL) && xl_ack && !xl_fault;
  assign whole      = kind_whole(kind_q);
  assign wants_wb   = kind_writes_back(kind_q);
  assign busy       = (st_q != ST_IDLE);
  assign xl_req     = (st_q == ST_XL);

  pmc_status #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (start_pg),
    .wdata    (reg_wdata),
    .fault_evt(fault_evt),
    .busy     (busy),
    .vpn      (xl_vpn),
    .inv_only (st_inv_only),
    .fault    (st_fault),
    .rdata    (reg_rdata)
  );

  pmc_walk #(.IDX_W(IDX_W), .WAY_W(WAY_W), .WAYS(WAYS), .PGL_W(PGL_W), .SET_W(SET_W)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(walk_start),
    .whole(whole),
    .step (step),
    .idx  (idx),
    .way  (arr_way),
    .last (walk_last)
  );

  always_comb begin
    line_cur  = page_line(pfn_q, idx);
    arr_set   = whole ? idx[SET_W-1:0] : set_of(line_cur);
    tag_hit   = whole || (arr_tag == tag_of(line_cur));
    line_live = (line_st_e'(arr_state) != LS_INV);
    hit       = (st_q == ST_SCAN) && line_live && tag_hit;
    need_wb   = hit && (line_st_e'(arr_state) == LS_MOD) && wants_wb;
    wb_done   = (st_q == ST_WB) && wb_ack;
    arr_wr    = (hit && !need_wb) || wb_done;
    step      = ((st_q == ST_SCAN) && !need_wb) || wb_done;
    wb_req    = (st_q == ST_WB);
    wb_addr   = whole ? {arr_tag, idx[SET_W-1:0]} : line_cur;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_pg) st_d = ST_XL;
               else if (start_all) st_d = ST_SCAN;
      ST_XL:   if (fault_evt) st_d = ST_IDLE;
               else if (xl_ok_evt) st_d = ST_SCAN;
      ST_SCAN: if (need_wb) st_d = ST_WB;
               else if (walk_last) st_d = ST_IDLE;
      ST_WB:   if (wb_ack) st_d = walk_last ? ST_IDLE : ST_SCAN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_PG_FLUSH;
      pfn_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start_pg)
        kind_q <= reg_wdata[0] ? K_PG_INV : K_PG_FLUSH;
      else if (start_all)
        kind_q <= cmd_wbinv_all ? K_ALL_WB : K_ALL_INV;
      if (xl_ok_evt)
        pfn_q <= xl_pfn;
    end
  end

  assert_start_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pg |=> busy && xl_req);
  assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !busy && st_fault);
  assert_mode_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !whole) |-> (st_inv_only == (kind_q == K_PG_INV)));
  assert_wb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> wb_req && $stable(wb_addr));
  assert_inv_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && (line_st_e'(arr_state) == LS_MOD) && wants_wb) |-> wb_ack);
  assert_no_wb_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wants_wb) |-> !wb_req);
  assert_skip_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st_e'(arr_state) == LS_INV) |-> !arr_wr && !wb_req);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arr_wr && !wb_req && !xl_req);
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(xl_vpn));
endmodule

// File: tb/sim_page_maint_ctrl.sv
module sim_page_maint_ctrl;
  localparam int NS = 128;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_wbinv_all = 1'b0;
  logic        cmd_inv_all = 1'b0;
  logic        busy;
  logic        xl_req;
  logic [19:0] xl_vpn;
  logic        xl_ack = 1'b0;
  logic        xl_fault = 1'b0;
  logic [19:0] xl_pfn = '0;
  logic [6:0]  arr_set;
  logic [0:0]  arr_way;
  logic [1:0]  arr_state;
  logic [19:0] arr_tag;
  logic        arr_wr;
  logic        wb_req;
  logic [26:0] wb_addr;
  logic        wb_ack = 1'b0;

  logic [1:0]  m_st  [NS][NW];
  logic [19:0] m_tag [NS][NW];
  logic [1:0]  e_st  [NS][NW];
  logic [26:0] exp_q [$];

  logic        cfg_fault = 1'b0;
  logic [19:0] cfg_pfn = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  page_maint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_wbinv_all(cmd_wbinv_all), .cmd_inv_all(cmd_inv_all),
    .busy(busy), .xl_req(xl_req), .xl_vpn(xl_vpn), .xl_ack(xl_ack),
    .xl_fault(xl_fault), .xl_pfn(xl_pfn), .arr_set(arr_set), .arr_way(arr_way),
    .arr_state(arr_state), .arr_tag(arr_tag), .arr_wr(arr_wr),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
  );

  always_comb begin
    arr_state = m_st[arr_set][arr_way];
    arr_tag   = m_tag[arr_set][arr_way];
  end

  always @(posedge clk) if (rst_n && arr_wr) m_st[arr_set][arr_way] <= 2'd0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // translation responder
  int xcnt = 0;
  always @(negedge clk) begin
    if (xl_req && !xl_ack) begin
      if (xcnt == 2) begin
        xl_ack = 1'b1; xl_fault = cfg_fault; xl_pfn = cfg_pfn; xcnt = 0;
      end else xcnt++;
    end else begin
      xl_ack = 1'b0; xl_fault = 1'b0;
    end
  end

  // write-back responder and scoreboard monitor
  int wcnt = 0;
  always @(negedge clk) begin
    if (wb_req && !wb_ack) begin
      if (wcnt == 1) begin
        wb_ack = 1'b1; wcnt = 0;
        chk(m_st[wb_addr[6:0]][arr_way] == 2'd3, "R4 line still modified at ack",
            64'(m_st[wb_addr[6:0]][arr_way]), 64'd3);
        if (exp_q.size() == 0)
          chk(1'b0, "R5 R9 unexpected write-back", 64'(wb_addr), 64'd0);
        else begin
          logic [26:0] e;
          e = exp_q.pop_front();
          chk(wb_addr == e, "R4 R7 R8 write-back address/order", 64'(wb_addr), 64'(e));
        end
      end else wcnt++;
    end else wb_ack = 1'b0;
  end

  task automatic fill(input logic [19:0] pfn);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_st[s][w]  = 2'((s + 2 * w) % 4);
        m_tag[s][w] = (s % 5 == w) ? (pfn ^ 20'h00F0F) : pfn;
        e_st[s][w]  = m_st[s][w];
      end
  endtask

  task automatic expect_page(input logic [19:0] pfn, input bit inv);
    for (int i = 0; i < NS; i++)
      for (int w = 0; w < NW; w++)
        if (m_tag[i][w] == pfn && m_st[i][w] != 2'd0) begin
          if (m_st[i][w] == 2'd3 && !inv) exp_q.push_back({pfn, 7'(i)});
          e_st[i][w] = 2'd0;
        end
  endtask

  task automatic expect_all(input bit wb);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        if (m_st[s][w] == 2'd3 && wb) exp_q.push_back({m_tag[s][w], 7'(s)});
        e_st[s][w] = 2'd0;
      end
  endtask

  task automatic cmp_array(input string what);
    int bad = 0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (m_st[s][w] != e_st[s][w]) bad++;
    chk(bad == 0, what, 64'(bad), 64'd0);
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    chk(!busy, "R1 walk finished", 64'(busy), 64'd0);
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 R8 all expected write-backs seen", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    fill(20'h0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xl_req && !wb_req && !arr_wr, "R11 reset outputs quiet", 64'({busy, xl_req, wb_req, arr_wr}), 64'd0);
    chk(reg_rdata == 32'd0, "R11 reset readback", 64'(reg_rdata), 64'd0);

    // flush with translation to a different frame
    cfg_pfn = 20'h0ABCD; cfg_fault = 1'b0;
    fill(cfg_pfn); expect_page(cfg_pfn, 1'b0);
    write_reg({20'h12345, 12'h000});
    chk(busy, "R1 busy after write", 64'(busy), 64'd1);
    chk(xl_req && xl_vpn == 20'h12345, "R1 translation request", 64'({xl_req, xl_vpn}), 64'({1'b1, 20'h12345}));
    chk(reg_rdata[1] == 1'b0, "R3 fault cleared by write", 64'(reg_rdata[1]), 64'd0);
    wait_idle();
    cmp_array("R4 R6 array after flush");
    chk(reg_rdata == {20'h12345, 12'h000}, "R3 R11 readback after flush", 64'(reg_rdata), 64'({20'h12345, 12'h000}));

    // invalidate-only
    cfg_pfn = 20'h54321;
    fill(cfg_pfn); expect_page(cfg_pfn, 1'b1);
    write_reg({20'h00077, 12'h001});
    wait_idle();
    cmp_array("R5 R6 array after invalidate-only");
    chk(reg_rdata == {20'h00077, 12'h001}, "R11 readback action bit", 64'(reg_rdata), 64'({20'h00077, 12'h001}));

    // faults in both modes
    for (int m = 0; m < 2; m++) begin
      cfg_fault = 1'b1;
      fill(cfg_pfn);
      write_reg({20'h0DEAD, 11'h0, 1'(m)});
      wait_idle();
      cmp_array("R2 array untouched on fault");
      chk(reg_rdata[1] == 1'b1, "R2 fault bit set", 64'(reg_rdata[1]), 64'd1);
    end

    // next write clears fault
    cfg_fault = 1'b0; cfg_pfn = 20'h0BEEF;
    fill(cfg_pfn); expect_page(cfg_pfn, 1'b0);
    write_reg({20'h0CAFE, 12'h000});
    chk(reg_rdata[1] == 1'b0, "R3 fault cleared next cycle", 64'(reg_rdata[1]), 64'd0);
    wait_idle();
    chk(reg_rdata[1] == 1'b0, "R3 fault stays clear on success", 64'(reg_rdata[1]), 64'd0);
    cmp_array("R4 array after second flush");

    // requests while busy are ignored
    cfg_pfn = 20'h01111;
    fill(cfg_pfn); expect_page(cfg_pfn, 1'b0);
    write_reg({20'h0AAAA, 12'h000});
    repeat (6) @(negedge clk);
    write_reg({20'h0BBBB, 12'h001});
    cmd_inv_all = 1'b1; @(negedge clk); cmd_inv_all = 1'b0;
    cmd_wbinv_all = 1'b1; @(negedge clk); cmd_wbinv_all = 1'b0;
    wait_idle();
    cmp_array("R10 busy requests ignored");
    chk(reg_rdata[31:12] == 20'h0AAAA, "R10 page field kept", 64'(reg_rdata[31:12]), 64'h0AAAA);

    // whole-cache write-back and invalidate, both commands together
    fill(20'h03333); expect_all(1'b1);
    @(negedge clk); cmd_wbinv_all = 1'b1; cmd_inv_all = 1'b1;
    @(negedge clk); cmd_wbinv_all = 1'b0; cmd_inv_all = 1'b0;
    chk(busy && !xl_req, "R8 whole walk needs no translation", 64'({busy, xl_req}), 64'(2'b10));
    wait_idle();
    cmp_array("R8 R10 all invalid after wbinv");

    // whole-cache invalidate
    fill(20'h04444); expect_all(1'b0);
    @(negedge clk); cmd_inv_all = 1'b1;
    @(negedge clk); cmd_inv_all = 1'b0;
    wait_idle();
    cmp_array("R9 all invalid after inv");

    // control write wins over same-cycle command
    cfg_pfn = 20'h05555;
    fill(cfg_pfn); expect_page(cfg_pfn, 1'b1);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = {20'h06666, 12'h001}; cmd_wbinv_all = 1'b1;
    @(negedge clk); reg_wr = 1'b0; cmd_wbinv_all = 1'b0;
    chk(xl_req && xl_vpn == 20'h06666, "R10 write wins over command", 64'({xl_req, xl_vpn}), 64'({1'b1, 20'h06666}));
    wait_idle();
    cmp_array("R5 R10 page walk after priority");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule